// File: doc/BRIEF.md
# Waveform Fill Acquisition Controller

This block sequences the capture of one digitiser channel. Each fabric clock, a parallel input carries several 12-bit samples in time order. A decoded trigger from the timing link starts a fill. The fill's capture length comes from one of three programmable length registers: muon fill, pedestal and laser calibration. A broadcast mode command, received before the trigger, selects which register applies. A fill is a single unbroken run of input beats, with no gaps, and the captured samples leave on a wide buffer write port.

Each fill is written in one of two formats. In padded form, every sample takes a 16-bit slot and its top four bits are zero. In dense form, the 12-bit samples are packed end to end, so every four samples use exactly three 16-bit slots. Every accepted trigger enters a small queue of fill records. A reader takes the records in trigger order. It sees a record only after that fill has been fully written, and then learns the fill's mode and how many bus words it produced. A trigger that arrives during a capture is rejected, and a trigger that arrives while the queue is full is dropped. Each case has its own saturating counter.

Top module: `fill_capture_ctrl`

## Requirements
- R1: After a synchronous reset, wr_valid, fill_ready and busy are low, both error counters read zero, the active mode is muon fill (code 0) and the length registers hold their reset values (defaults 64, 16 and 32 samples for codes 0, 1 and 2).
- R2: A cycle with cfg_we high loads cfg_len into the length register picked by cfg_sel (0 muon, 1 pedestal, 2 laser). A write with cfg_sel = 3 or with cfg_len = 0 changes no register.
- R3: mode_valid with mode_sel of 0, 1 or 2 sets the active mode for later triggers, and mode_sel = 3 is ignored. The mode in force when a trigger is accepted is reported as fill_mode for that fill.
- R4: A trigger is accepted when the block is idle and the queue is not full. The samp_in beat of the trigger cycle is the first beat, and lane i (bits 12i+11:12i) is the i-th sample in time. Capture takes ceil(L/LANES) consecutive beats for the mode's length L, and each beat's output appears one cycle after that beat is taken in.
- R5: With pack_en low at the trigger, each output beat holds one 16-bit slot per lane, with the sample in bits 16i+11:16i and zeros in bits 16i+15:16i+12. Lanes past sample L-1 in the last beat are zero.
- R6: With pack_en high at the trigger, sample k takes stream bits 12k+11:12k. Stream bit j is written to output beat j/64, bit j mod 64. Samples missing from the last input beat are zero, and the unused bits of the final output beat are zero.
- R7: The record of a finished fill gives, as fill_words, the number of output beats that fill wrote.
- R8: fill_ready is high exactly when the oldest queued fill has finished, and it stays low while that fill is still being captured. A cycle with rd_req high while fill_ready is high removes that record. Records come out in trigger order.
- R9: A trigger that arrives while a capture or its closing flush cycle is in progress is rejected. trig_err_cnt then increments, saturating at its maximum, and the capture in progress is not affected.
- R10: busy is high while the queue holds FIFO_DEPTH records. A trigger during that time starts no capture and increments trig_drop_cnt, saturating at its maximum.
- R11: wr_valid is never high in the cycle after an idle cycle without a trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Length register write strobe |
| cfg_sel | input | 2 | Length register select (0 muon, 1 pedestal, 2 laser) |
| cfg_len | input | LEN_W | Capture length in samples |
| mode_valid | input | 1 | Mode command strobe |
| mode_sel | input | 2 | Mode command code |
| pack_en | input | 1 | Dense 12-bit format when high at trigger |
| trig | input | 1 | Decoded trigger |
| samp_in | input | LANES*SAMPLE_W | Sample beat, lane 0 earliest |
| wr_valid | output | 1 | Buffer write strobe |
| wr_data | output | 16*LANES | Buffer write word |
| fill_ready | output | 1 | Oldest fill record is complete |
| fill_words | output | LEN_W | Output beats of oldest fill |
| fill_mode | output | 2 | Mode of oldest fill |
| rd_req | input | 1 | Take oldest fill record |
| busy | output | 1 | Fill queue full |
| trig_err_cnt | output | CNT_W | Triggers rejected during capture |
| trig_drop_cnt | output | CNT_W | Triggers dropped on full queue |

## Verification
A wrong lane mask or a wrong packing offset appears in the very first output beat of a fill that has a short or unaligned length. A wrong remaining count or a missed flush shows up two to three cycles after the last input beat, as an extra or missing write beat and as a wrong fill_words value. Queue pointer faults reach the ports only when records are read back. The bench therefore fills the queue completely before draining it, so that a wrong order or wrong mode shows up on the next read. An accept gate that ignores the busy or capturing condition produces a write beat within one cycle of the stray trigger.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  typedef enum logic [1:0] {
    ACQ_MUON  = 2'd0,
    ACQ_PED   = 2'd1,
    ACQ_LASER = 2'd2
  } acq_mode_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CAP   = 2'd1,
    ST_FLUSH = 2'd2
  } seq_state_t;

  localparam int SLOT_W = 16;
endpackage

// File: rtl/fcc_len_regs.sv
module fcc_len_regs #(
  parameter int LEN_W     = 16,
  parameter int RST_MUON  = 64,
  parameter int RST_PED   = 16,
  parameter int RST_LASER = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [1:0]       sel,
  input  logic [LEN_W-1:0] wdata,
  input  logic [1:0]       rd_sel,
  output logic [LEN_W-1:0] rd_len
);
  localparam int NREG = 3;

  logic [LEN_W-1:0] len_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam int RV = (g == 0) ? RST_MUON : (g == 1) ? RST_PED : RST_LASER;
    always_ff @(posedge clk) begin
      if (rst) begin
        len_q[g] <= LEN_W'(RV);
      end else if (we && (sel == 2'(g)) && (wdata != '0)) begin
        len_q[g] <= wdata;
      end
    end
  end

  always_comb begin
    case (rd_sel)
      2'd1:    rd_len = len_q[1];
      2'd2:    rd_len = len_q[2];
      default: rd_len = len_q[0];
    endcase
  end
endmodule

// File: rtl/fcc_packer.sv
module fcc_packer #(
  parameter int SAMPLE_W = 12,
  parameter int LANES    = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      beat_valid,
  input  logic                      pack_mode,
  input  logic                      flush,
  input  logic [LANES*SAMPLE_W-1:0] lane_data,
  output logic                      emit_now,
  output logic                      out_valid,
  output logic [16*LANES-1:0]       out_data
);
  localparam int OUT_W = fcc_pkg::SLOT_W * LANES;
  localparam int IN_W  = SAMPLE_W * LANES;
  localparam int ACC_W = 2 * OUT_W;
  localparam int CW    = $clog2(ACC_W) + 1;

  logic [ACC_W-1:0] acc_q, acc_ins, acc_n;
  logic [CW-1:0]    fill_q, fill_sum;
  logic [OUT_W-1:0] padded;

  for (genvar g = 0; g < LANES; g++) begin : g_pad
    assign padded[fcc_pkg::SLOT_W*g +: fcc_pkg::SLOT_W] =
      {{(fcc_pkg::SLOT_W-SAMPLE_W){1'b0}}, lane_data[SAMPLE_W*g +: SAMPLE_W]};
  end

  always_comb begin
    acc_ins  = {{(ACC_W-IN_W){1'b0}}, lane_data} << fill_q;
    acc_n    = acc_q | acc_ins;
    fill_sum = fill_q + CW'(IN_W);
    emit_now = 1'b0;
    if (beat_valid) begin
      emit_now = pack_mode ? (fill_sum >= CW'(OUT_W)) : 1'b1;
    end else if (flush) begin
      emit_now = (fill_q != '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      fill_q    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= emit_now;
      if (beat_valid && pack_mode) begin
        if (emit_now) begin
          out_data <= acc_n[OUT_W-1:0];
          acc_q    <= acc_n >> OUT_W;
          fill_q   <= fill_sum - CW'(OUT_W);
        end else begin
          acc_q  <= acc_n;
          fill_q <= fill_sum;
        end
      end else if (beat_valid) begin
        out_data <= padded;
      end else if (flush) begin
        if (fill_q != '0) out_data <= acc_q[OUT_W-1:0];
        acc_q  <= '0;
        fill_q <= '0;
      end
    end
  end
endmodule

// File: rtl/fcc_fill_fifo.sv
module fcc_fill_fifo #(
  parameter int DEPTH = 4,
  parameter int LEN_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [1:0]                 push_mode,
  input  logic                       fin,
  input  logic [LEN_W-1:0]           fin_words,
  input  logic                       pop,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic [LEN_W-1:0]           head_words,
  output logic [1:0]                 head_mode
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [LEN_W-1:0] mem_words [DEPTH];
  logic [1:0]       mem_mode  [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr, last_ptr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem_mode[wr_ptr] <= push_mode;
    if (fin)  mem_words[last_ptr] <= fin_words;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      last_ptr <= '0;
      count    <= '0;
    end else begin
      if (push) begin
        last_ptr <= wr_ptr;
        wr_ptr   <= bump(wr_ptr);
      end
      if (pop) rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign full       = (count == CW'(DEPTH));
  assign head_words = mem_words[rd_ptr];
  assign head_mode  = mem_mode[rd_ptr];
endmodule

// File: rtl/fill_capture_ctrl.sv
module fill_capture_ctrl #(
  parameter int SAMPLE_W      = 12,
  parameter int LANES         = 4,
  parameter int LEN_W         = 16,
  parameter int FIFO_DEPTH    = 4,
  parameter int CNT_W         = 8,
  parameter int RST_LEN_MUON  = 64,
  parameter int RST_LEN_PED   = 16,
  parameter int RST_LEN_LASER = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_we,
  input  logic [1:0]                cfg_sel,
  input  logic [LEN_W-1:0]          cfg_len,
  input  logic                      mode_valid,
  input  logic [1:0]                mode_sel,
  input  logic                      pack_en,
  input  logic                      trig,
  input  logic [LANES*SAMPLE_W-1:0] samp_in,
  output logic                      wr_valid,
  output logic [16*LANES-1:0]       wr_data,
  output logic                      fill_ready,
  output logic [LEN_W-1:0]          fill_words,
  output logic [1:0]                fill_mode,
  input  logic                      rd_req,
  output logic                      busy,
  output logic [CNT_W-1:0]          trig_err_cnt,
  output logic [CNT_W-1:0]          trig_drop_cnt
);
  import fcc_pkg::*;

  localparam int IN_W = SAMPLE_W * LANES;
  localparam int QCW  = $clog2(FIFO_DEPTH + 1);

  seq_state_t       state;
  logic [1:0]       mode_q;
  logic             pack_q;
  logic [LEN_W-1:0] remaining, beats, cur_len, len_now;
  logic             in_idle, capturing, accept, beat_valid, last_beat;
  logic             pack_now, flush, emit_now, fifo_full, pop;
  logic [QCW-1:0]   q_count;
  logic [IN_W-1:0]  lane_data;

  fcc_len_regs #(
    .LEN_W(LEN_W), .RST_MUON(RST_LEN_MUON),
    .RST_PED(RST_LEN_PED), .RST_LASER(RST_LEN_LASER)
  ) u_len (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_len),
    .rd_sel(mode_q), .rd_len(cur_len)
  );

  assign in_idle    = (state == ST_IDLE);
  assign capturing  = !in_idle;
  assign accept     = trig && in_idle && !fifo_full;
  assign beat_valid = accept || (state == ST_CAP);
  assign flush      = (state == ST_FLUSH);
  assign len_now    = in_idle ? cur_len : remaining;
  assign last_beat  = (len_now <= LEN_W'(LANES));
  assign pack_now   = in_idle ? pack_en : pack_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_data[SAMPLE_W*g +: SAMPLE_W] =
      (LEN_W'(g) < len_now) ? samp_in[SAMPLE_W*g +: SAMPLE_W] : '0;
  end

  fcc_packer #(.SAMPLE_W(SAMPLE_W), .LANES(LANES)) u_pack (
    .clk(clk), .rst(rst), .beat_valid(beat_valid), .pack_mode(pack_now),
    .flush(flush), .lane_data(lane_data), .emit_now(emit_now),
    .out_valid(wr_valid), .out_data(wr_data)
  );

  fcc_fill_fifo #(.DEPTH(FIFO_DEPTH), .LEN_W(LEN_W)) u_fifo (
    .clk(clk), .rst(rst), .push(accept), .push_mode(mode_q),
    .fin(flush), .fin_words(beats + LEN_W'(emit_now)), .pop(pop),
    .full(fifo_full), .count(q_count), .head_words(fill_words),
    .head_mode(fill_mode)
  );

  assign fill_ready = (q_count != '0) && !((q_count == QCW'(1)) && capturing);
  assign pop        = rd_req && fill_ready;
  assign busy       = fifo_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= ACQ_MUON;
    end else if (mode_valid && (mode_sel != 2'd3)) begin
      mode_q <= mode_sel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      pack_q    <= 1'b0;
      remaining <= '0;
      beats     <= '0;
    end else begin
      if (beat_valid) remaining <= len_now - LEN_W'(LANES);
      if (accept) begin
        pack_q <= pack_en;
        beats  <= LEN_W'(emit_now);
      end else if (beat_valid || flush) begin
        beats <= beats + LEN_W'(emit_now);
      end
      case (state)
        ST_IDLE:  if (accept) state <= last_beat ? ST_FLUSH : ST_CAP;
        ST_CAP:   if (last_beat) state <= ST_FLUSH;
        ST_FLUSH: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_err_cnt  <= '0;
      trig_drop_cnt <= '0;
    end else begin
      if (trig && capturing && (trig_err_cnt != '1))
        trig_err_cnt <= trig_err_cnt + 1'b1;
      if (trig && in_idle && fifo_full && (trig_drop_cnt != '1))
        trig_drop_cnt <= trig_drop_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fcc_checker.sv
module fcc_checker #(
  parameter int SAMPLE_W = 12,
  parameter int LANES    = 4,
  parameter int LEN_W    = 16,
  parameter int CNT_W    = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                trig,
  input logic                busy,
  input logic                in_idle,
  input logic                capturing,
  input logic                pack_q,
  input logic                wr_valid,
  input logic [16*LANES-1:0] wr_data,
  input logic                fill_ready,
  input logic [LEN_W-1:0]    fill_words,
  input logic [CNT_W-1:0]    err_cnt,
  input logic [CNT_W-1:0]    drop_cnt
);
  function automatic logic [16*LANES-1:0] hi_mask();
    logic [16*LANES-1:0] m = '0;
    for (int l = 0; l < LANES; l++)
      for (int b = SAMPLE_W; b < 16; b++) m[16*l + b] = 1'b1;
    return m;
  endfunction

  localparam logic [16*LANES-1:0] HI_MASK = hi_mask();

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    (in_idle && !trig) |=> !wr_valid);

  assert_pad_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !pack_q) |-> ((wr_data & HI_MASK) == '0));

  assert_err_count_R9: assert property (@(posedge clk) disable iff (rst)
    (trig && capturing && (err_cnt != '1)) |=> (err_cnt == CNT_W'($past(err_cnt) + 1'b1)));

  assert_drop_count_R10: assert property (@(posedge clk) disable iff (rst)
    (trig && in_idle && busy && (drop_cnt != '1)) |=> (drop_cnt == CNT_W'($past(drop_cnt) + 1'b1)));

  assert_ready_words_R7: assert property (@(posedge clk) disable iff (rst)
    fill_ready |-> (fill_words != '0));

  assert_busy_no_write_R10: assert property (@(posedge clk) disable iff (rst)
    (trig && in_idle && busy) |=> !wr_valid);
endmodule

bind fill_capture_ctrl fcc_checker #(
  .SAMPLE_W(SAMPLE_W), .LANES(LANES), .LEN_W(LEN_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .trig(trig), .busy(busy), .in_idle(in_idle),
  .capturing(capturing), .pack_q(pack_q), .wr_valid(wr_valid),
  .wr_data(wr_data), .fill_ready(fill_ready), .fill_words(fill_words),
  .err_cnt(trig_err_cnt), .drop_cnt(trig_drop_cnt)
);

// File: tb/fill_capture_ctrl_tb.sv
`timescale 1ns/1ps
module fill_capture_ctrl_tb;
  localparam int LANES = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [15:0] cfg_len = '0;
  logic        mode_valid = 1'b0;
  logic [1:0]  mode_sel = '0;
  logic        pack_en = 1'b0;
  logic        trig = 1'b0;
  logic [47:0] samp_in = '0;
  logic        wr_valid;
  logic [63:0] wr_data;
  logic        fill_ready;
  logic [15:0] fill_words;
  logic [1:0]  fill_mode;
  logic        rd_req = 1'b0;
  logic        busy;
  logic [7:0]  trig_err_cnt, trig_drop_cnt;

  fill_capture_ctrl u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_len(cfg_len),
    .mode_valid(mode_valid), .mode_sel(mode_sel), .pack_en(pack_en), .trig(trig),
    .samp_in(samp_in), .wr_valid(wr_valid), .wr_data(wr_data),
    .fill_ready(fill_ready), .fill_words(fill_words), .fill_mode(fill_mode),
    .rd_req(rd_req), .busy(busy), .trig_err_cnt(trig_err_cnt),
    .trig_drop_cnt(trig_drop_cnt)
  );

  always #4 clk = ~clk;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;
  logic [11:0] smp [0:1023];
  logic [63:0] exp_w [0:255];
  logic [63:0] got_w [0:255];
  int got_n = 0;
  int exp_len [3] = '{64, 16, 32};
  int mq_mode [0:63];
  int mq_words [0:63];
  int mq_wr = 0, mq_rd = 0;
  int exp_err = 0, exp_drop = 0;

  always @(negedge clk) begin
    if (wr_valid) begin
      if (got_n < 256) got_w[got_n] = wr_data;
      got_n++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int build_exp(input int len, input bit pk);
    int nb = (len + LANES - 1) / LANES;
    int nw = pk ? (nb * 48 + 63) / 64 : nb;
    for (int i = 0; i <= nw; i++) exp_w[i] = '0;
    for (int k = 0; k < nb * LANES; k++) begin
      logic [11:0] s = (k < len) ? smp[k] : 12'd0;
      if (!pk) begin
        exp_w[k / LANES][16 * (k % LANES) +: 16] = {4'b0, s};
      end else begin
        for (int b = 0; b < 12; b++) begin
          int j = 12 * k + b;
          exp_w[j / 64][j % 64] = s[b];
        end
      end
    end
    return nw;
  endfunction

  task automatic write_len(input int sel, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_len = 16'(val);
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel < 3 && val != 0) exp_len[sel] = val;
  endtask

  task automatic run_fill(input int mode, input bit pk, input bit extra_trig,
                          input bit bad_mode, input string tag);
    int len, nb, nw;
    bit was_empty = (mq_wr == mq_rd);
    @(negedge clk);
    mode_valid = 1'b1; mode_sel = 2'(mode);
    @(negedge clk);
    if (bad_mode) begin
      mode_sel = 2'd3;
      @(negedge clk);
    end
    mode_valid = 1'b0; pack_en = pk;
    len = exp_len[mode];
    nb  = (len + LANES - 1) / LANES;
    got_n = 0;
    for (int b = 0; b < nb; b++) begin
      if (b > 0) @(negedge clk);
      if (b == 1 && was_empty)
        check(fill_ready == 1'b0, "R8 ready while capturing", 64'(fill_ready), 64'd0);
      for (int l = 0; l < LANES; l++) begin
        smp[b * LANES + l] = 12'($urandom);
        samp_in[12 * l +: 12] = smp[b * LANES + l];
      end
      trig = (b == 0) || (extra_trig && b == 2);
    end
    @(negedge clk);
    trig = 1'b0;
    samp_in = 48'($urandom);
    repeat (4) @(negedge clk);
    if (extra_trig) exp_err++;
    nw = build_exp(len, pk);
    check(got_n == nw, {tag, " beat count"}, 64'(got_n), 64'(nw));
    for (int i = 0; i < nw && i < 256; i++)
      check(got_w[i] == exp_w[i], pk ? "R6 packed word" : "R5 padded word", got_w[i], exp_w[i]);
    if (extra_trig)
      check(trig_err_cnt == 8'(exp_err), "R9 reject count", 64'(trig_err_cnt), 64'(exp_err));
    mq_mode[mq_wr % 64] = mode;
    mq_words[mq_wr % 64] = nw;
    mq_wr++;
  endtask

  task automatic read_fill();
    @(negedge clk);
    check(fill_ready == 1'b1, "R8 ready", 64'(fill_ready), 64'd1);
    check(fill_words == 16'(mq_words[mq_rd % 64]), "R7 word count", 64'(fill_words), 64'(mq_words[mq_rd % 64]));
    check(fill_mode == 2'(mq_mode[mq_rd % 64]), "R3 fill mode", 64'(fill_mode), 64'(mq_mode[mq_rd % 64]));
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    mq_rd++;
  endtask

  initial begin
    int unsigned seed_set;
    seed_set = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!wr_valid && !fill_ready && !busy, "R1 outputs idle",
          {61'd0, wr_valid, fill_ready, busy}, 64'd0);
    check(trig_err_cnt == 0 && trig_drop_cnt == 0, "R1 counters",
          {48'd0, trig_err_cnt, trig_drop_cnt}, 64'd0);

    // R1 default lengths, R4 basic capture
    run_fill(0, 1'b0, 1'b0, 1'b0, "R1 default muon");
    read_fill();
    run_fill(1, 1'b1, 1'b0, 1'b0, "R1 default pedestal");
    read_fill();

    // R2 length writes, odd lengths, R5/R6 tails
    write_len(0, 5);
    run_fill(0, 1'b1, 1'b0, 1'b0, "R4 len5 packed");
    read_fill();
    write_len(2, 1);
    run_fill(2, 1'b0, 1'b0, 1'b0, "R4 len1 padded");
    read_fill();
    write_len(1, 7);
    run_fill(1, 1'b0, 1'b0, 1'b0, "R4 len7 padded");
    read_fill();
    write_len(1, 0);
    write_len(3, 9);
    run_fill(1, 1'b1, 1'b0, 1'b0, "R2 zero/sel3 ignored");
    read_fill();

    // R3 mode code 3 ignored
    write_len(2, 16);
    run_fill(2, 1'b1, 1'b0, 1'b1, "R3 bad mode ignored");
    read_fill();

    // R9 trigger during capture
    write_len(0, 33);
    run_fill(0, 1'b1, 1'b1, 1'b0, "R9 capture unaffected");
    read_fill();

    // R10 queue full
    run_fill(0, 1'b0, 1'b0, 1'b0, "R10 fill 1");
    run_fill(1, 1'b1, 1'b0, 1'b0, "R10 fill 2");
    run_fill(2, 1'b0, 1'b0, 1'b0, "R10 fill 3");
    run_fill(1, 1'b0, 1'b0, 1'b0, "R10 fill 4");
    @(negedge clk);
    check(busy == 1'b1, "R10 busy", 64'(busy), 64'd1);
    got_n = 0;
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    repeat (3) @(negedge clk);
    exp_drop++;
    check(got_n == 0, "R10 no capture when full", 64'(got_n), 64'd0);
    check(trig_drop_cnt == 8'(exp_drop), "R10 drop count", 64'(trig_drop_cnt), 64'(exp_drop));
    for (int i = 0; i < 4; i++) read_fill();
    @(negedge clk);
    check(!busy && !fill_ready, "R8 queue drained", {62'd0, busy, fill_ready}, 64'd0);

    // Random fills
    for (int r = 0; r < 24; r++) begin
      int m = int'($urandom % 3);
      write_len(m, 1 + int'($urandom % 120));
      run_fill(m, 1'($urandom), 1'b0, 1'b0, "R4 random fill");
      if (r % 3 != 0) begin
        while (mq_rd != mq_wr) read_fill();
      end
    end
    while (mq_rd != mq_wr) read_fill();

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule